// File: doc/BRIEF.md
# Programmable Transmit Pulse Sample Generator

The block turns a stream of line symbols into signed amplitude samples for a transmit DAC. It runs at sixteen samples per unit interval (UI). A host writes a pulse template of up to four UIs into a small sample store. Each UI of the template holds sixteen sub-phase samples.

On every UI boundary the block takes one symbol from a positive-rail and a negative-rail mark input. A mark launches a pulse that reads the template UI by UI for the next four UIs. A negative mark uses the template with its polarity inverted. Because the pulses are longer than one UI, the tails of up to four symbols are added together at each sample.

The sum is then processed in three steps:
- It is checked for overflow. Overflow sets a sticky flag, and the flag can raise an interrupt.
- In the user-template mode only, it is multiplied by a programmable scale, where code 33 means unity gain.
- It is saturated to the sample range.

Top module: `tx_pulse_gen`

## Requirements
- R1: After reset, sample_o, ovf_o, irq_o and cfg_rdata_o are all zero and the scale register holds 33 (unity gain).
- R2: A cfg_done_i cycle with cfg_rd_i=0 writes cfg_wdata_i to the sample at (cfg_ui_i, cfg_phase_i). A cfg_done_i cycle with cfg_rd_i=1 returns that sample on cfg_rdata_o one edge later. cfg_rdata_o keeps its value in all cycles without cfg_done_i.
- R3: A free-running sub-phase counter counts 0..15 from reset. sym_take_o is high in the cycle where the counter is 15, which first happens in the 16th cycle after reset. The marks are sampled at the edge that ends that cycle.
- R4: Samples use the sign-magnitude format, with bit 6 as the sign (1 = negative) and bits 5:0 as the magnitude. After a lone positive mark is taken, the output after edge 16*k+p+1 equals template sample (k, p), for k = 0..3 and p = 0..15. A zero result is always driven as 7'b0000000.
- R5: A lone negative mark produces the template with every sign inverted. Both marks high, or neither, adds no pulse.
- R6: The contributions of the last four taken symbols are added sample by sample, and the output is computed from that signed sum.
- R7: When the magnitude of the sum exceeds 63, ovf_o is set at the same edge and stays set until cfg clear. ovf_clr_i clears it unless a new overflow happens at the same edge, in which case set wins. An output magnitude above 63 saturates to 63.
- R8: irq_o is high exactly when ovf_o is high and ovf_ie_i is high.
- R9: When pulse_sel_i[3:2] is 2'b11, the output magnitude is |sum|*scale/33, truncated toward zero, then saturated. scale_we_i loads scale_wdata_i at the next edge.
- R10: In any other pulse_sel_i setting, the output magnitude is |sum|, unscaled, whatever the scale register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, 16x the symbol rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_ui_i | input | 2 | Template UI index for host access |
| cfg_phase_i | input | 4 | Template sub-phase index for host access |
| cfg_wdata_i | input | 7 | Sample to write (sign-magnitude) |
| cfg_rd_i | input | 1 | Access direction: 0 write, 1 read |
| cfg_done_i | input | 1 | Strobe that performs the access |
| cfg_rdata_o | output | 7 | Read-back sample |
| scale_we_i | input | 1 | Load the scale register |
| scale_wdata_i | input | 6 | New scale value |
| pulse_sel_i | input | 4 | Pulse select; 11xx selects the user template with scaling |
| mark_p_i | input | 1 | Positive-rail mark |
| mark_n_i | input | 1 | Negative-rail mark |
| sym_take_o | output | 1 | Marks are taken at the end of this cycle |
| sample_o | output | 7 | Output sample (sign-magnitude) |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| ovf_clr_i | input | 1 | Clear the overflow flag |
| ovf_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Overflow interrupt |

## Verification
Each output sample is registered, so the result for the sub-phase counted in a given cycle appears one edge later. A symbol taken at the edge that ends a sym_take_o cycle therefore shows its UI k, phase p sample after edge 16k+p+1. The overflow flag is updated at that same edge. A read returns its data one edge after the done strobe, and irq_o follows ovf_o combinationally. The bench steps a reference model at every rising edge, pushes the expected sample and flag into a queue, and pops them on the falling edge that follows. It samples read data on the falling edge after the strobe and checks irq_o shortly after changing the enable.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  typedef enum logic [1:0] {
    SYM_SPACE = 2'd0,
    SYM_POS   = 2'd1,
    SYM_NEG   = 2'd2
  } sym_e;

  localparam logic [1:0] SEL_USER = 2'b11;
endpackage

// File: rtl/tpg_tmpl_ram.sv
module tpg_tmpl_ram #(
  parameter int UI_N = 4,
  parameter int PH_N = 16,
  parameter int SW   = 7,
  localparam int UIW = $clog2(UI_N),
  localparam int PHW = $clog2(PH_N)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [UIW-1:0]           acc_ui_i,
  input  logic [PHW-1:0]           acc_ph_i,
  input  logic [SW-1:0]            acc_wdata_i,
  input  logic                     acc_rd_i,
  input  logic                     acc_done_i,
  output logic [SW-1:0]            acc_rdata_o,
  input  logic [PHW-1:0]           ph_i,
  output logic [UI_N-1:0][SW-1:0]  tap_o
);
  logic [SW-1:0] mem_q [UI_N][PH_N];
  logic [SW-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int u = 0; u < UI_N; u++)
        for (int p = 0; p < PH_N; p++)
          mem_q[u][p] <= '0;
    end else if (acc_done_i && !acc_rd_i) begin
      mem_q[acc_ui_i][acc_ph_i] <= acc_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      rdata_q <= '0;
    else if (acc_done_i && acc_rd_i)  rdata_q <= mem_q[acc_ui_i][acc_ph_i];
  end

  assign acc_rdata_o = rdata_q;

  // one read tap per UI of the template at the live sub-phase
  for (genvar k = 0; k < UI_N; k++) begin : g_tap
    assign tap_o[k] = mem_q[k][ph_i];
  end
endmodule

// File: rtl/tpg_sym_hist.sv
module tpg_sym_hist
  import tpg_pkg::*;
#(
  parameter int UI_N = 4,
  parameter int PH_N = 16,
  localparam int PHW = $clog2(PH_N)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  mark_p_i,
  input  logic                  mark_n_i,
  output logic [PHW-1:0]        ph_o,
  output logic                  take_o,
  output sym_e [UI_N-1:0]       hist_o
);
  localparam logic [PHW-1:0] PH_LAST = PHW'(PH_N - 1);

  logic [PHW-1:0]  ph_q;
  sym_e [UI_N-1:0] hist_q;
  sym_e            sym_new;

  always_comb begin
    unique case ({mark_p_i, mark_n_i})
      2'b10:   sym_new = SYM_POS;
      2'b01:   sym_new = SYM_NEG;
      default: sym_new = SYM_SPACE;
    endcase
  end

  assign take_o = (ph_q == PH_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      hist_q <= {UI_N{SYM_SPACE}};
    end else begin
      ph_q <= take_o ? '0 : ph_q + 1'b1;
      if (take_o) hist_q <= {hist_q[UI_N-2:0], sym_new};
    end
  end

  assign ph_o   = ph_q;
  assign hist_o = hist_q;
endmodule

// File: rtl/tpg_sum_scale.sv
module tpg_sum_scale
  import tpg_pkg::*;
#(
  parameter int UI_N      = 4,
  parameter int SW        = 7,
  parameter int SCW       = 6,
  parameter int SCALE_REF = 33,
  localparam int MAGW   = SW - 1,
  localparam int MAXMAG = (1 << MAGW) - 1,
  localparam int SUMW   = SW + $clog2(UI_N) + 1,
  localparam int PRW    = SUMW + SCW
) (
  input  logic [UI_N-1:0][SW-1:0] tap_i,
  input  sym_e [UI_N-1:0]         hist_i,
  input  logic                    user_i,
  input  logic [SCW-1:0]          scale_i,
  output logic [SW-1:0]           out_o,
  output logic                    ovf_o
);
  logic signed [SUMW-1:0] contrib [UI_N];
  logic signed [SUMW-1:0] sum;
  logic [SUMW-1:0]        abs_sum;
  logic [PRW-1:0]         prod, quot, pick;
  logic [MAGW-1:0]        out_mag;

  for (genvar k = 0; k < UI_N; k++) begin : g_term
    logic signed [SUMW-1:0] mag;
    logic                   neg;
    assign mag = $signed({{(SUMW-MAGW){1'b0}}, tap_i[k][MAGW-1:0]});
    assign neg = tap_i[k][SW-1] ^ (hist_i[k] == SYM_NEG);
    assign contrib[k] = (hist_i[k] == SYM_SPACE) ? '0 : (neg ? -mag : mag);
  end

  always_comb begin
    sum = '0;
    for (int k = 0; k < UI_N; k++) sum = sum + contrib[k];
  end

  assign abs_sum = sum[SUMW-1] ? $unsigned(-sum) : $unsigned(sum);
  assign ovf_o   = abs_sum > SUMW'(MAXMAG);

  assign prod = {{SCW{1'b0}}, abs_sum} * {{SUMW{1'b0}}, scale_i};
  assign quot = prod / PRW'(SCALE_REF);
  assign pick = user_i ? quot : {{SCW{1'b0}}, abs_sum};

  assign out_mag = (pick > PRW'(MAXMAG)) ? '1 : pick[MAGW-1:0];
  assign out_o   = (out_mag == '0) ? '0 : {sum[SUMW-1], out_mag};
endmodule

// File: rtl/tx_pulse_gen.sv
module tx_pulse_gen
  import tpg_pkg::*;
#(
  parameter int UI_N      = 4,
  parameter int PH_N      = 16,
  parameter int SW        = 7,
  parameter int SCW       = 6,
  parameter int SEL_W     = 4,
  parameter int SCALE_RST = 33,
  parameter int SCALE_REF = 33,
  localparam int UIW = $clog2(UI_N),
  localparam int PHW = $clog2(PH_N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [UIW-1:0]   cfg_ui_i,
  input  logic [PHW-1:0]   cfg_phase_i,
  input  logic [SW-1:0]    cfg_wdata_i,
  input  logic             cfg_rd_i,
  input  logic             cfg_done_i,
  output logic [SW-1:0]    cfg_rdata_o,
  input  logic             scale_we_i,
  input  logic [SCW-1:0]   scale_wdata_i,
  input  logic [SEL_W-1:0] pulse_sel_i,
  input  logic             mark_p_i,
  input  logic             mark_n_i,
  output logic             sym_take_o,
  output logic [SW-1:0]    sample_o,
  input  logic             ovf_ie_i,
  input  logic             ovf_clr_i,
  output logic             ovf_o,
  output logic             irq_o
);
  logic [PHW-1:0]          ph;
  sym_e [UI_N-1:0]         hist;
  logic [UI_N-1:0][SW-1:0] tap;
  logic [SW-1:0]           sample_d, sample_q;
  logic [SCW-1:0]          scale_q;
  logic                    sum_ovf, ovf_q, user_mode;
  logic                    unused_sel;

  assign user_mode  = (pulse_sel_i[SEL_W-1 -: 2] == SEL_USER);
  assign unused_sel = ^pulse_sel_i[SEL_W-3:0];

  tpg_tmpl_ram #(.UI_N(UI_N), .PH_N(PH_N), .SW(SW)) u_ram (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_ui_i   (cfg_ui_i),
    .acc_ph_i   (cfg_phase_i),
    .acc_wdata_i(cfg_wdata_i),
    .acc_rd_i   (cfg_rd_i),
    .acc_done_i (cfg_done_i),
    .acc_rdata_o(cfg_rdata_o),
    .ph_i       (ph),
    .tap_o      (tap)
  );

  tpg_sym_hist #(.UI_N(UI_N), .PH_N(PH_N)) u_hist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mark_p_i(mark_p_i),
    .mark_n_i(mark_n_i),
    .ph_o    (ph),
    .take_o  (sym_take_o),
    .hist_o  (hist)
  );

  tpg_sum_scale #(.UI_N(UI_N), .SW(SW), .SCW(SCW), .SCALE_REF(SCALE_REF)) u_sum (
    .tap_i  (tap),
    .hist_i (hist),
    .user_i (user_mode),
    .scale_i(scale_q),
    .out_o  (sample_d),
    .ovf_o  (sum_ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scale_q  <= SCW'(SCALE_RST);
      sample_q <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (scale_we_i) scale_q <= scale_wdata_i;
      sample_q <= sample_d;
      if (sum_ovf)        ovf_q <= 1'b1;   // set wins over clear
      else if (ovf_clr_i) ovf_q <= 1'b0;
    end
  end

  assign sample_o = sample_q;
  assign ovf_o    = ovf_q;
  assign irq_o    = ovf_q & ovf_ie_i;
endmodule

// File: rtl/tpg_chk.sv
module tpg_chk #(
  parameter int SW = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sym_take_o,
  input logic [SW-1:0] sample_o,
  input logic          ovf_o,
  input logic          irq_o,
  input logic          ovf_ie_i,
  input logic          ovf_clr_i,
  input logic          cfg_done_i,
  input logic [SW-1:0] cfg_rdata_o,
  input logic          sum_ovf_i
);
  p_take_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_take_o |=> !sym_take_o);

  p_rdata_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_done_i |=> $stable(cfg_rdata_o));

  p_no_neg_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o != {1'b1, {(SW-1){1'b0}}});

  p_ovf_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_ovf_i |=> ovf_o);

  p_ovf_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !ovf_clr_i |=> ovf_o);

  p_ovf_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_clr_i && !sum_ovf_i |=> !ovf_o);

  p_irq_needs_ovf_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ovf_o);

  p_irq_masked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovf_ie_i |-> !irq_o);
endmodule

bind tx_pulse_gen tpg_chk #(.SW(SW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sym_take_o (sym_take_o),
  .sample_o   (sample_o),
  .ovf_o      (ovf_o),
  .irq_o      (irq_o),
  .ovf_ie_i   (ovf_ie_i),
  .ovf_clr_i  (ovf_clr_i),
  .cfg_done_i (cfg_done_i),
  .cfg_rdata_o(cfg_rdata_o),
  .sum_ovf_i  (sum_ovf)
);

// File: tb/tb_tx_pulse_gen.sv
module tb_tx_pulse_gen;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] cfg_ui = '0;
  logic [3:0] cfg_phase = '0;
  logic [6:0] cfg_wdata = '0;
  logic       cfg_rd = 1'b0, cfg_done = 1'b0;
  logic [6:0] cfg_rdata;
  logic       scale_we = 1'b0;
  logic [5:0] scale_wdata = '0;
  logic [3:0] pulse_sel = '0;
  logic       mark_p = 1'b0, mark_n = 1'b0;
  logic       sym_take;
  logic [6:0] sample;
  logic       ovf_ie = 1'b0, ovf_clr = 1'b0;
  logic       ovf, irq;

  always #5 clk = ~clk;

  tx_pulse_gen dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_ui_i(cfg_ui), .cfg_phase_i(cfg_phase), .cfg_wdata_i(cfg_wdata),
    .cfg_rd_i(cfg_rd), .cfg_done_i(cfg_done), .cfg_rdata_o(cfg_rdata),
    .scale_we_i(scale_we), .scale_wdata_i(scale_wdata),
    .pulse_sel_i(pulse_sel), .mark_p_i(mark_p), .mark_n_i(mark_n),
    .sym_take_o(sym_take), .sample_o(sample),
    .ovf_ie_i(ovf_ie), .ovf_clr_i(ovf_clr), .ovf_o(ovf), .irq_o(irq)
  );

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R4";
  bit    run = 1'b0, done = 1'b0, sat_seen = 1'b0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model
  logic [6:0] mem_m [4][16];
  int         hist_m [4];
  int         ph_m = 0;
  int         scale_m = 33;
  bit         ovf_m = 1'b0;
  logic [7:0] exp_q [$];

  function automatic int sm2i(logic [6:0] v);
    int m;
    m = int'(v[5:0]);
    return v[6] ? -m : m;
  endfunction

  initial begin
    for (int u = 0; u < 4; u++) begin
      hist_m[u] = 0;
      for (int p = 0; p < 16; p++) mem_m[u][p] = '0;
    end
  end

  always @(posedge clk) begin
    int s, a, m;
    logic [6:0] e;
    if (run) begin
      s = 0;
      for (int k = 0; k < 4; k++) s += hist_m[k] * sm2i(mem_m[k][ph_m]);
      a = (s < 0) ? -s : s;
      m = (pulse_sel[3:2] == 2'b11) ? (a * scale_m) / 33 : a;
      if (m > 63) m = 63;
      e = (m == 0) ? 7'd0 : {(s < 0), 6'(m)};
      if (a > 63) ovf_m = 1'b1;
      else if (ovf_clr) ovf_m = 1'b0;
      exp_q.push_back({ovf_m, e});
      if (cfg_done && !cfg_rd) mem_m[cfg_ui][cfg_phase] = cfg_wdata;
      if (scale_we) scale_m = int'(scale_wdata);
      if (ph_m == 15) begin
        for (int k = 3; k > 0; k--) hist_m[k] = hist_m[k-1];
        hist_m[0] = (mark_p && !mark_n) ? 1 : ((mark_n && !mark_p) ? -1 : 0);
      end
      ph_m = (ph_m + 1) % 16;
    end
  end

  // monitor
  always @(negedge clk) begin
    logic [7:0] it;
    if (run && exp_q.size() > 0) begin
      it = exp_q.pop_front();
      chk(sample == it[6:0], cur_req, int'(sample), int'(it[6:0]));
      chk(ovf == it[7], "R7", int'(ovf), int'(it[7]));
      chk(sym_take == (ph_m == 15), "R3", int'(sym_take), int'(ph_m == 15));
      if (sample[5:0] == 6'd63) sat_seen = 1'b1;
    end
  end

  task automatic wr(int u, int p, logic [6:0] v);
    @(negedge clk);
    cfg_ui = 2'(u); cfg_phase = 4'(p); cfg_wdata = v; cfg_rd = 1'b0; cfg_done = 1'b1;
    @(negedge clk);
    cfg_done = 1'b0;
  endtask

  task automatic rd_chk(int u, int p, logic [6:0] exp);
    @(negedge clk);
    cfg_ui = 2'(u); cfg_phase = 4'(p); cfg_rd = 1'b1; cfg_done = 1'b1;
    @(negedge clk);
    cfg_done = 1'b0; cfg_rd = 1'b0;
    chk(cfg_rdata == exp, "R2", int'(cfg_rdata), int'(exp));
  endtask

  task automatic send(bit p, bit n);
    @(negedge clk);
    while (!sym_take) @(negedge clk);
    mark_p = p; mark_n = n;
    @(negedge clk);
    mark_p = 1'b0; mark_n = 1'b0;
  endtask

  task automatic idle_ui(int n);
    for (int i = 0; i < n; i++) send(1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sample == 7'd0, "R1", int'(sample), 0);
    chk(ovf == 1'b0, "R1", int'(ovf), 0);
    chk(irq == 1'b0, "R1", int'(irq), 0);
    chk(cfg_rdata == 7'd0, "R1", int'(cfg_rdata), 0);
    rst_ni = 1'b1;
    run = 1'b1;

    // R2: load template, read back
    for (int p = 0; p < 16; p++) begin
      wr(0, p, {1'b0, 6'(10 + 3 * p)});
      wr(1, p, {1'b1, 6'(p)});
      wr(2, p, 7'd2);
      wr(3, p, 7'h41);
    end
    rd_chk(0, 5, 7'd25);
    rd_chk(1, 15, 7'h4f);
    rd_chk(3, 0, 7'h41);
    repeat (4) @(negedge clk);
    chk(cfg_rdata == 7'h41, "R2", int'(cfg_rdata), 'h41);

    // R4/R5: isolated pulses, preset mode
    cur_req = "R4";
    send(1'b1, 1'b0); idle_ui(4);
    cur_req = "R5";
    send(1'b0, 1'b1); idle_ui(4);
    send(1'b1, 1'b1); idle_ui(4);
    chk(sample == 7'd0, "R5", int'(sample), 0);

    // R6: overlapping pulses
    cur_req = "R6";
    send(1'b1, 1'b0); send(1'b0, 1'b1); send(1'b1, 1'b0);
    send(1'b1, 1'b0); send(1'b0, 1'b1); idle_ui(4);

    // R7/R8: overflow via large second UI
    cur_req = "R7";
    for (int p = 0; p < 16; p++) wr(1, p, 7'd60);
    send(1'b1, 1'b0); send(1'b1, 1'b0); idle_ui(4);
    chk(ovf == 1'b1, "R7", int'(ovf), 1);
    chk(sat_seen, "R7", int'(sat_seen), 1);
    chk(irq == 1'b0, "R8", int'(irq), 0);
    ovf_ie = 1'b1;
    #1;
    chk(irq == 1'b1, "R8", int'(irq), 1);
    @(negedge clk);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    chk(ovf == 1'b0, "R7", int'(ovf), 0);
    chk(irq == 1'b0, "R8", int'(irq), 0);
    for (int p = 0; p < 16; p++) wr(1, p, {1'b1, 6'(p)});

    // R9: user mode with default and programmed scale
    cur_req = "R9";
    pulse_sel = 4'b1100;
    send(1'b1, 1'b0); idle_ui(4);
    @(negedge clk);
    scale_we = 1'b1; scale_wdata = 6'd40;
    @(negedge clk);
    scale_we = 1'b0;
    send(1'b1, 1'b0); send(1'b0, 1'b1); idle_ui(4);
    @(negedge clk);
    scale_we = 1'b1; scale_wdata = 6'd20;
    @(negedge clk);
    scale_we = 1'b0;
    pulse_sel = 4'b1111;
    send(1'b0, 1'b1); send(1'b1, 1'b0); idle_ui(4);

    // R10: preset mode ignores scale
    cur_req = "R10";
    pulse_sel = 4'b0101;
    send(1'b1, 1'b0); send(1'b1, 1'b0); idle_ui(4);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule